// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block sits beside the transmit and receive FIFOs of a serial port. It takes their occupancy counts and turns them into level flags and interrupt requests. Each direction has its own 3-bit level code, which picks a threshold as a fraction of the FIFO depth. The receive flag is raised once enough entries are stored. The transmit flag is raised once enough entries are free.

The block also holds a sticky wakeup flag. A 2-bit selector picks which receive-side event pulse sets that flag, and an enable gates the flag onto a wakeup interrupt.

The FIFO storage is not part of this block. Only the counts and the event pulses arrive at its ports. The depth is a parameter that must be a multiple of 8, and every threshold is derived from it at elaboration.

Top module: `uart_fifo_thresh_irq`

## Requirements
- R1: While `rst_n` is low, `rx_lvl_flag`, `tx_lvl_flag`, `wake_flag` and all three interrupt outputs are 0.
- R2: Level codes map to thresholds of DEPTH as follows: 6 gives 1/2, 0 gives 1/8, 4 gives 7/8, 1 gives 1/4, 3 gives 3/4 and 5 gives DEPTH. `rx_lvl_flag` is 1 one clock after a cycle in which `rx_count` is at least the threshold of `rx_lvl_sel`. With code 5 this means the receive FIFO is full.
- R3: The transmit free space is DEPTH minus `tx_count`, taken as 0 when `tx_count` exceeds DEPTH. `tx_lvl_flag` is 1 one clock after a cycle in which the free space is at least the threshold of `tx_lvl_sel`. With code 5 this means the transmit FIFO is empty.
- R4: Codes 2 and 7 are reserved. A reserved code never raises the flag of its direction, whatever the count.
- R5: A level flag is 0 one clock after a cycle in which its condition does not hold. This applies to a change of count and to a change of code alike.
- R6: `rx_lvl_irq` equals `rx_lvl_flag & rx_lvl_ie`, and `tx_lvl_irq` equals `tx_lvl_flag & tx_lvl_ie`, in the same cycle.
- R7: `wake_sel` chooses which pulse sets `wake_flag` on the next clock: 0 selects `ev_addr_hit`, 2 selects `ev_start_bit` and 3 selects `ev_rx_ready`. Pulses that are not selected are ignored.
- R8: With `wake_sel` = 1, no event sets `wake_flag`.
- R9: `wake_flag` stays set until a cycle with `wake_clr` high, and is 0 after that clock. If a selected event arrives in the same cycle as `wake_clr`, the flag is set.
- R10: `wake_irq` equals `wake_flag & wake_ie` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_count | input | $clog2(DEPTH+1) | Entries held in the receive FIFO |
| tx_count | input | $clog2(DEPTH+1) | Entries held in the transmit FIFO |
| rx_lvl_sel | input | 3 | Receive level code |
| tx_lvl_sel | input | 3 | Transmit level code |
| rx_lvl_ie | input | 1 | Receive level interrupt enable |
| tx_lvl_ie | input | 1 | Transmit level interrupt enable |
| wake_sel | input | 2 | Wakeup event select |
| wake_ie | input | 1 | Wakeup interrupt enable |
| ev_addr_hit | input | 1 | Address-match pulse |
| ev_start_bit | input | 1 | Start-bit detection pulse |
| ev_rx_ready | input | 1 | Receive-data-ready pulse |
| wake_clr | input | 1 | Clears the wakeup flag |
| rx_lvl_flag | output | 1 | Receive level reached |
| tx_lvl_flag | output | 1 | Transmit free-space level reached |
| rx_lvl_irq | output | 1 | Receive level interrupt |
| tx_lvl_irq | output | 1 | Transmit level interrupt |
| wake_flag | output | 1 | Sticky wakeup flag |
| wake_irq | output | 1 | Wakeup interrupt |

## Verification
The hardest cases to reach are the exact boundaries: a count one below a threshold and a count exactly at it, for each valid code. A purely random count seldom lands on both sides of the same threshold under the same code. Directed sweeps therefore walk every code across its threshold in both directions, and the reserved codes are tried with full and empty FIFOs.

The other hard case is a selected wakeup event and a clear landing in the same cycle. It is forced directly. Random traffic then mixes codes, counts slightly above DEPTH, wakeup pulses and clears, all against a bench model.

// File: rtl/uft_pkg.sv
package uft_pkg;

   localparam logic [2:0] LVL_EIGHTH  = 3'd0;
   localparam logic [2:0] LVL_QUARTER = 3'd1;
   localparam logic [2:0] LVL_THREEQ  = 3'd3;
   localparam logic [2:0] LVL_SEVEN8  = 3'd4;
   localparam logic [2:0] LVL_END     = 3'd5;
   localparam logic [2:0] LVL_HALF    = 3'd6;

   typedef enum logic [1:0] {
      WK_ADDR  = 2'd0,
      WK_NONE  = 2'd1,
      WK_START = 2'd2,
      WK_READY = 2'd3
   } wake_sel_e;

   function automatic logic code_ok(input logic [2:0] code);
      return (code != 3'd2) && (code != 3'd7);
   endfunction

   function automatic int unsigned level_of(input logic [2:0] code, input int unsigned depth);
      case (code)
         LVL_EIGHTH:  return depth / 8;
         LVL_QUARTER: return depth / 4;
         LVL_HALF:    return depth / 2;
         LVL_THREEQ:  return (depth / 4) * 3;
         LVL_SEVEN8:  return (depth / 8) * 7;
         LVL_END:     return depth;
         default:     return 0;
      endcase
   endfunction

endpackage

// File: rtl/uft_level_cmp.sv
module uft_level_cmp #(
   parameter int unsigned DEPTH = 16,
   parameter bit          IS_TX = 1'b0,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [2:0]       sel_i,
   output logic             flag_o
);
   import uft_pkg::*;

   localparam int unsigned CW1     = CNT_W + 1;
   localparam logic [CW1-1:0] DEPTH_V = CW1'(DEPTH);

   if ((DEPTH % 8) != 0 || DEPTH < 8) begin : g_bad_depth
      $error("uft_level_cmp: DEPTH must be a nonzero multiple of 8");
   end

   logic [CW1-1:0] occ_ext;
   logic [CW1-1:0] measure;
   logic [CW1-1:0] thr;
   logic           hit;
   logic           flag_q;

   assign occ_ext = {1'b0, count_i};

   if (IS_TX) begin : g_tx
      // free entries, saturating at zero for an out-of-range count
      assign measure = (occ_ext > DEPTH_V) ? '0 : (DEPTH_V - occ_ext);
   end else begin : g_rx
      assign measure = occ_ext;
   end

   always_comb begin
      thr = CW1'(level_of(sel_i, DEPTH));
      hit = code_ok(sel_i) && (measure >= thr);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= hit;
   end

   assign flag_o = flag_q;

   p_res_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !code_ok($past(sel_i)) |-> !flag_o);

   if (IS_TX) begin : g_tx_chk
      p_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sel_i) == LVL_END && $past(count_i) == '0) |-> flag_o);
      p_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sel_i) == LVL_END && $past(count_i) != '0) |-> !flag_o);
   end else begin : g_rx_chk
      p_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(sel_i) == LVL_END && {1'b0, $past(count_i)} >= DEPTH_V) |-> flag_o);
      p_empty_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(count_i) == '0) |-> !flag_o);
   end

endmodule

// File: rtl/uft_wake_sel.sv
module uft_wake_sel (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       addr_ev_i,
   input  logic       start_ev_i,
   input  logic       rdy_ev_i,
   input  logic       clr_i,
   output logic       flag_o
);
   import uft_pkg::*;

   wake_sel_e sel;
   logic      hit;
   logic      flag_q;

   assign sel = wake_sel_e'(sel_i);

   always_comb begin
      case (sel)
         WK_ADDR:  hit = addr_ev_i;
         WK_START: hit = start_ev_i;
         WK_READY: hit = rdy_ev_i;
         default:  hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (hit)   flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_sel_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_i) == 2'd1 && !$past(flag_o)) |-> !flag_o);

   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag_o) && !$past(clr_i)) |-> flag_o);

   p_ready_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_i) == 2'd3 && $past(rdy_ev_i)) |-> flag_o);

endmodule

// File: rtl/uart_fifo_thresh_irq.sv
module uart_fifo_thresh_irq #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] rx_count,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [2:0]       rx_lvl_sel,
   input  logic [2:0]       tx_lvl_sel,
   input  logic             rx_lvl_ie,
   input  logic             tx_lvl_ie,
   input  logic [1:0]       wake_sel,
   input  logic             wake_ie,
   input  logic             ev_addr_hit,
   input  logic             ev_start_bit,
   input  logic             ev_rx_ready,
   input  logic             wake_clr,
   output logic             rx_lvl_flag,
   output logic             tx_lvl_flag,
   output logic             rx_lvl_irq,
   output logic             tx_lvl_irq,
   output logic             wake_flag,
   output logic             wake_irq
);

   uft_level_cmp #(.DEPTH(DEPTH), .IS_TX(1'b0), .CNT_W(CNT_W)) rx_cmp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (rx_count),
      .sel_i   (rx_lvl_sel),
      .flag_o  (rx_lvl_flag)
   );

   uft_level_cmp #(.DEPTH(DEPTH), .IS_TX(1'b1), .CNT_W(CNT_W)) tx_cmp_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .count_i (tx_count),
      .sel_i   (tx_lvl_sel),
      .flag_o  (tx_lvl_flag)
   );

   uft_wake_sel wake_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (wake_sel),
      .addr_ev_i  (ev_addr_hit),
      .start_ev_i (ev_start_bit),
      .rdy_ev_i   (ev_rx_ready),
      .clr_i      (wake_clr),
      .flag_o     (wake_flag)
   );

   assign rx_lvl_irq = rx_lvl_flag & rx_lvl_ie;
   assign tx_lvl_irq = tx_lvl_flag & tx_lvl_ie;
   assign wake_irq   = wake_flag & wake_ie;

   p_rst_quiet_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> !(rx_lvl_flag | tx_lvl_flag | wake_flag));

endmodule

// File: tb/uart_fifo_thresh_irq_tb_top.sv
module uart_fifo_thresh_irq_tb_top;
   localparam int unsigned DEPTH = 16;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] rx_count = '0, tx_count = '0;
   logic [2:0] rx_lvl_sel = '0, tx_lvl_sel = '0;
   logic rx_lvl_ie = 0, tx_lvl_ie = 0, wake_ie = 0;
   logic [1:0] wake_sel = '0;
   logic ev_addr_hit = 0, ev_start_bit = 0, ev_rx_ready = 0, wake_clr = 0;
   logic rx_lvl_flag, tx_lvl_flag, rx_lvl_irq, tx_lvl_irq, wake_flag, wake_irq;

   int checks = 0;
   int fails  = 0;
   bit exp_wake = 0;

   always #2 clk = ~clk;

   uart_fifo_thresh_irq #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .rx_count(rx_count), .tx_count(tx_count),
      .rx_lvl_sel(rx_lvl_sel), .tx_lvl_sel(tx_lvl_sel),
      .rx_lvl_ie(rx_lvl_ie), .tx_lvl_ie(tx_lvl_ie),
      .wake_sel(wake_sel), .wake_ie(wake_ie),
      .ev_addr_hit(ev_addr_hit), .ev_start_bit(ev_start_bit),
      .ev_rx_ready(ev_rx_ready), .wake_clr(wake_clr),
      .rx_lvl_flag(rx_lvl_flag), .tx_lvl_flag(tx_lvl_flag),
      .rx_lvl_irq(rx_lvl_irq), .tx_lvl_irq(tx_lvl_irq),
      .wake_flag(wake_flag), .wake_irq(wake_irq)
   );

   function automatic int ref_level(input logic [2:0] c);
      case (c)
         3'd0: return DEPTH / 8;
         3'd1: return DEPTH / 4;
         3'd3: return 3 * DEPTH / 4;
         3'd4: return 7 * DEPTH / 8;
         3'd5: return DEPTH;
         3'd6: return DEPTH / 2;
         default: return -1;
      endcase
   endfunction

   function automatic bit ref_rx(input logic [2:0] c, input int cnt);
      return ref_level(c) >= 0 && cnt >= ref_level(c);
   endfunction

   function automatic bit ref_tx(input logic [2:0] c, input int cnt);
      int fr;
      fr = (cnt > DEPTH) ? 0 : DEPTH - cnt;
      return ref_level(c) >= 0 && fr >= ref_level(c);
   endfunction

   function automatic bit ref_hit(input logic [1:0] s, input bit a, input bit st, input bit r);
      case (s)
         2'd0: return a;
         2'd2: return st;
         2'd3: return r;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // inputs are applied 1 ns after an edge; results are read 1 ns after the next
   task automatic step();
      exp_wake = ref_hit(wake_sel, ev_addr_hit, ev_start_bit, ev_rx_ready) ? 1'b1 :
                 (wake_clr ? 1'b0 : exp_wake);
      @(posedge clk);
      #1;
   endtask

   task automatic apply_lvl(input logic [2:0] rs, input int rc, input logic [2:0] ts, input int tc);
      rx_lvl_sel = rs; rx_count = CNT_W'(rc);
      tx_lvl_sel = ts; tx_count = CNT_W'(tc);
      step();
      chk("R2/R4/R5 rx flag", rx_lvl_flag, ref_rx(rs, rc));
      chk("R3/R4/R5 tx flag", tx_lvl_flag, ref_tx(ts, tc));
      chk("R6 rx irq", rx_lvl_irq, ref_rx(rs, rc) & rx_lvl_ie);
      chk("R6 tx irq", tx_lvl_irq, ref_tx(ts, tc) & tx_lvl_ie);
   endtask

   task automatic pulse(input logic [1:0] s, input bit a, input bit st, input bit r, input bit clr);
      wake_sel = s; ev_addr_hit = a; ev_start_bit = st; ev_rx_ready = r; wake_clr = clr;
      step();
      ev_addr_hit = 0; ev_start_bit = 0; ev_rx_ready = 0; wake_clr = 0;
      chk("R7/R8/R9 wake flag", wake_flag, exp_wake);
      chk("R10 wake irq", wake_irq, exp_wake & wake_ie);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0c3a));
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet during reset
      chk("R1 rx flag", rx_lvl_flag, 0);
      chk("R1 tx flag", tx_lvl_flag, 0);
      chk("R1 wake flag", wake_flag, 0);
      chk("R1 irqs", {rx_lvl_irq, tx_lvl_irq, wake_irq}, 0);
      rst_n = 1'b1;
      rx_lvl_ie = 1; tx_lvl_ie = 1; wake_ie = 1;

      // R2/R3/R5: every code walked across its threshold both ways
      for (int c = 0; c < 8; c++) begin
         int lv;
         lv = ref_level(3'(c));
         if (lv < 0) lv = DEPTH / 2;
         apply_lvl(3'(c), lv - 1, 3'(c), DEPTH - lv + 1);
         apply_lvl(3'(c), lv,     3'(c), DEPTH - lv);
         apply_lvl(3'(c), lv - 1, 3'(c), DEPTH - lv + 1);
      end
      // R4: reserved codes with full and empty FIFOs
      apply_lvl(3'd2, DEPTH, 3'd7, 0);
      apply_lvl(3'd7, DEPTH, 3'd2, 0);
      // R2 code 5 full, R3 code 5 empty, then a code switch dropping (R5)
      apply_lvl(3'd5, DEPTH, 3'd5, 0);
      apply_lvl(3'd2, DEPTH, 3'd7, 0);
      // R3: count above DEPTH saturates free space to 0
      apply_lvl(3'd0, 0, 3'd0, DEPTH + 1);
      // R6: enable gating
      rx_lvl_ie = 0; tx_lvl_ie = 0;
      apply_lvl(3'd0, DEPTH, 3'd0, 0);
      rx_lvl_ie = 1; tx_lvl_ie = 1;
      apply_lvl(3'd0, DEPTH, 3'd0, 0);

      // R7: each select with a matching and non-matching pulse
      pulse(2'd0, 0, 1, 1, 0);
      pulse(2'd0, 1, 0, 0, 0);
      pulse(2'd0, 0, 0, 0, 1);
      pulse(2'd2, 1, 0, 1, 0);
      pulse(2'd2, 0, 1, 0, 0);
      pulse(2'd2, 0, 0, 0, 1);
      pulse(2'd3, 1, 1, 0, 0);
      pulse(2'd3, 0, 0, 1, 0);
      // R9: sticky hold, then set beats clear
      pulse(2'd3, 0, 0, 0, 0);
      pulse(2'd3, 0, 0, 1, 1);
      pulse(2'd1, 0, 0, 0, 1);
      // R8: select 1 ignores all pulses
      pulse(2'd1, 1, 1, 1, 0);
      // R10: interrupt gating
      wake_ie = 0;
      pulse(2'd0, 1, 0, 0, 0);
      wake_ie = 1;
      pulse(2'd0, 0, 0, 0, 0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         rx_lvl_ie = 1'($urandom);
         tx_lvl_ie = 1'($urandom);
         wake_ie   = 1'($urandom);
         wake_sel = 2'($urandom);
         ev_addr_hit = ($urandom % 4) == 0;
         ev_start_bit = ($urandom % 4) == 0;
         ev_rx_ready = ($urandom % 4) == 0;
         wake_clr = ($urandom % 3) == 0;
         apply_lvl(3'($urandom), int'($urandom % (DEPTH + 3)),
                   3'($urandom), int'($urandom % (DEPTH + 3)));
         ev_addr_hit = 0; ev_start_bit = 0; ev_rx_ready = 0; wake_clr = 0;
         chk("R7/R9 random wake flag", wake_flag, exp_wake);
         chk("R10 random wake irq", wake_irq, exp_wake & wake_ie);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule